// File: doc/BRIEF.md
# PHY management register front-end

This block is the software-facing side of the management path between an Ethernet MAC and its PHY. Software issues PHY register reads and writes by programming a small set of memory-mapped registers. These are a command register, an address register that selects the PHY and the PHY register, a write-data register and a read-data register. So that the block stands alone, the PHY register file is modelled inside it. The model holds a control register, a status register whose link bit tracks an external link input, and a fixed gigabit status word.

A write to the command register that raises the read bit starts a read cycle. In the same clock, the result is latched into the read-data register. A write to the write-data register always launches a PHY write cycle in the same clock. Beside the management registers sits a bank of general-purpose registers. Each of them has a fixed access policy: read-write, write-only, write-1-to-clear or read-only.

Top module: `mgmt_frontend`

## Requirements
- R1: After reset the command, address, write-data and read-data registers read 0, and the modelled PHY control register holds 0x1140.
- R2: The address register keeps only bits 12:8 (PHY address) and bits 4:0 (PHY register number); all other bits read back as 0.
- R3: Only a command write that changes bit 0 of the command register from 0 to 1 starts a read cycle. Writing 1 while bit 0 is already 1 leaves the read-data register unchanged. The command register reads back the written value.
- R4: A read cycle of PHY register 0 returns the PHY control value, and a read cycle of register 1 returns the PHY status value, which is 0x7809 with bit 2 replaced by the link state.
- R5: A read cycle of PHY register 10 returns 0x1800. Any other register number returns 0. The result appears in bits 15:0 of the read-data register, and its upper bits read 0.
- R6: A write to the write-data register keeps only its low 16 bits (upper bits read 0) and starts a PHY write cycle in the same clock.
- R7: A PHY write cycle to register 0 stores the data with bits 15 and 8 forced to 0. Write cycles to any other register number change nothing.
- R8: The PHY address field has no effect: reads and writes reach the same modelled PHY whatever its value.
- R9: Bit 2 of the PHY status register equals the link_up input as sampled one clock earlier.
- R10: General register offset 4 is read-write and stores the full 32-bit value. Offset 5 is write-only and always reads 0.
- R11: General register offset 6 resets to W1C_INIT (default 0x000000FF), and each 1 written to it clears that bit; a 0 written leaves the bit unchanged.
- R12: General register offset 7 always reads RO_VALUE (default 0x00010001) and ignores writes. Unmapped offsets 8 to 15 read 0 and ignore writes.
- R13: Bus writes to the read-data register (offset 3) have no effect. Register offsets are 0 command, 1 address, 2 write-data, 3 read-data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Register word offset |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| link_up | input | 1 | Link state reported to the PHY status model |

## Verification
A corrupted PHY control or status value stays hidden until software runs a read cycle. It then shows up in the read-data register on the clock right after the command write, so the bench follows every PHY write with a rising-edge read. If the edge detector wrongly held bit 0 of the command register high, the next read request would leave a stale result in place. Re-issuing a read to a different register number exposes this at once. A wrong link flop shows within one read cycle after link_up changes.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

  typedef enum logic [1:0] {
    POL_RW  = 2'd0,
    POL_WO  = 2'd1,
    POL_W1C = 2'd2,
    POL_RO  = 2'd3
  } acc_pol_e;

  localparam int DATA_W   = 32;
  localparam int PHY_W    = 16;
  localparam int REGNUM_W = 5;

  // bus word offsets
  localparam int OFF_CMD  = 0;
  localparam int OFF_ADDR = 1;
  localparam int OFF_WDAT = 2;
  localparam int OFF_RDAT = 3;

  localparam int          CMD_RD_BIT = 0;
  localparam logic [31:0] ADDR_KEEP  = 32'h0000_1F1F;

  // modelled PHY register file
  localparam logic [REGNUM_W-1:0] PHY_REG_CTRL = 5'd0;
  localparam logic [REGNUM_W-1:0] PHY_REG_STAT = 5'd1;
  localparam logic [REGNUM_W-1:0] PHY_REG_T2   = 5'd10;
  localparam logic [PHY_W-1:0]    T2_VALUE     = 16'h1800;
  localparam logic [PHY_W-1:0]    CTRL_CLRMASK = 16'h8100;
  localparam logic [PHY_W-1:0]    CTRL_RESET   = 16'h1140;
  localparam logic [PHY_W-1:0]    STAT_BASE    = 16'h7809;
  localparam int                  LINK_BIT     = 2;

  function automatic acc_pol_e gen_policy(input int idx);
    case (idx % 4)
      0:       return POL_RW;
      1:       return POL_WO;
      2:       return POL_W1C;
      default: return POL_RO;
    endcase
  endfunction

endpackage

// File: rtl/mgmt_rst_sync.sv
module mgmt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mgmt_gen_reg.sv
module mgmt_gen_reg
  import mgmt_pkg::*;
#(
  parameter acc_pol_e    POLICY = POL_RW,
  parameter logic [31:0] INIT   = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  logic [31:0] val_q, val_d;

  always_comb begin
    val_d = val_q;
    if (we) begin
      case (POLICY)
        POL_RW, POL_WO: val_d = wdata;
        POL_W1C:        val_d = val_q & ~wdata;
        default:        val_d = val_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  val_q <= INIT;
    else if (we) val_q <= val_d;
  end

  assign rdata = (POLICY == POL_WO) ? 32'h0 : val_q;
endmodule

// File: rtl/mgmt_phy_model.sv
module mgmt_phy_model
  import mgmt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                link_up,
  input  logic                wr_go,
  input  logic [REGNUM_W-1:0] regnum,
  input  logic [PHY_W-1:0]    wr_data,
  output logic [PHY_W-1:0]    rd_data,
  output logic [PHY_W-1:0]    ctrl_o,
  output logic [PHY_W-1:0]    stat_o
);
  logic [PHY_W-1:0] ctrl_q, ctrl_d;
  logic             link_q;
  logic             ctrl_en;

  assign ctrl_en = wr_go && (regnum == PHY_REG_CTRL);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_en) ctrl_d = wr_data & ~CTRL_CLRMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RESET;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= 1'b0;
    else        link_q <= link_up;
  end

  always_comb begin
    stat_o           = STAT_BASE;
    stat_o[LINK_BIT] = link_q;
  end

  always_comb begin
    case (regnum)
      PHY_REG_CTRL: rd_data = ctrl_q;
      PHY_REG_STAT: rd_data = stat_o;
      PHY_REG_T2:   rd_data = T2_VALUE;
      default:      rd_data = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/mgmt_frontend.sv
module mgmt_frontend
  import mgmt_pkg::*;
#(
  parameter int          ADDR_W   = 4,
  parameter int          GEN_BASE = 4,
  parameter int          NUM_GEN  = 4,
  parameter logic [31:0] W1C_INIT = 32'h0000_00FF,
  parameter logic [31:0] RO_VALUE = 32'h0001_0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              link_up
);
  logic rst_core_n;

  mgmt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  // write decode
  logic cmd_wr, addr_wr, wdat_wr;
  assign cmd_wr  = bus_we && (bus_addr == ADDR_W'(OFF_CMD));
  assign addr_wr = bus_we && (bus_addr == ADDR_W'(OFF_ADDR));
  assign wdat_wr = bus_we && (bus_addr == ADDR_W'(OFF_WDAT));

  logic [31:0]      cmd_q, cmd_d;
  logic [31:0]      addr_q, addr_d;
  logic [PHY_W-1:0] wdat_q, wdat_d;
  logic [PHY_W-1:0] rdat_q, rdat_d;
  logic             rd_go;
  logic [PHY_W-1:0] phy_rd, phy_ctrl, phy_stat;

  assign rd_go = cmd_wr && bus_wdata[CMD_RD_BIT] && !cmd_q[CMD_RD_BIT];

  always_comb begin
    cmd_d  = bus_wdata;
    addr_d = bus_wdata & ADDR_KEEP;
    wdat_d = bus_wdata[PHY_W-1:0];
    rdat_d = phy_rd;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      cmd_q  <= '0;
      addr_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
    end else begin
      if (cmd_wr)  cmd_q  <= cmd_d;
      if (addr_wr) addr_q <= addr_d;
      if (wdat_wr) wdat_q <= wdat_d;
      if (rd_go)   rdat_q <= rdat_d;
    end
  end

  mgmt_phy_model u_phy (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .link_up (link_up),
    .wr_go   (wdat_wr),
    .regnum  (addr_q[REGNUM_W-1:0]),
    .wr_data (bus_wdata[PHY_W-1:0]),
    .rd_data (phy_rd),
    .ctrl_o  (phy_ctrl),
    .stat_o  (phy_stat)
  );

  // general-purpose register bank
  logic [31:0] gen_rd [NUM_GEN];

  for (genvar gi = 0; gi < NUM_GEN; gi++) begin : g_gen
    localparam acc_pol_e    POL = gen_policy(gi);
    localparam logic [31:0] INI = (POL == POL_W1C) ? W1C_INIT :
                                  (POL == POL_RO)  ? RO_VALUE : 32'h0;
    logic we_i;
    assign we_i = bus_we && (bus_addr == ADDR_W'(GEN_BASE + gi));
    mgmt_gen_reg #(.POLICY(POL), .INIT(INI)) u_reg (
      .clk   (clk),
      .rst_n (rst_core_n),
      .we    (we_i),
      .wdata (bus_wdata),
      .rdata (gen_rd[gi])
    );
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFF_CMD):  bus_rdata = cmd_q;
      ADDR_W'(OFF_ADDR): bus_rdata = addr_q;
      ADDR_W'(OFF_WDAT): bus_rdata = {16'h0, wdat_q};
      ADDR_W'(OFF_RDAT): bus_rdata = {16'h0, rdat_q};
      default: begin
        for (int i = 0; i < NUM_GEN; i++)
          if (bus_addr == ADDR_W'(GEN_BASE + i)) bus_rdata = gen_rd[i];
      end
    endcase
  end
endmodule

// File: rtl/mgmt_frontend_chk.sv
module mgmt_frontend_chk
  import mgmt_pkg::*;
#(
  parameter int          ADDR_W   = 4,
  parameter int          RO_OFF   = 7,
  parameter logic [31:0] RO_VALUE = 32'h0001_0001
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              link_up,
  input logic [31:0]       cmd_q,
  input logic [31:0]       addr_q,
  input logic [PHY_W-1:0]  rdat_q,
  input logic [PHY_W-1:0]  phy_ctrl,
  input logic [PHY_W-1:0]  phy_stat
);
  logic trig;
  assign trig = bus_we && (bus_addr == ADDR_W'(OFF_CMD)) &&
                bus_wdata[CMD_RD_BIT] && !cmd_q[CMD_RD_BIT];

  // R3 / R13: read-data register moves only on a rising read request
  assert_rdat_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |=> $stable(rdat_q));

  // R7: a PHY control write clears bits 15 and 8
  assert_ctrl_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFF_WDAT) && addr_q[4:0] == PHY_REG_CTRL)
    |=> (phy_ctrl[15] == 1'b0 && phy_ctrl[8] == 1'b0));

  // R9: link bit tracks link_up one clock later
  assert_link_track_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> phy_stat[LINK_BIT] == $past(link_up));

  // R6: write-data register upper half reads zero
  assert_wdat_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == ADDR_W'(OFF_WDAT) |-> bus_rdata[31:16] == 16'h0);

  // R12: read-only register returns its constant
  assert_ro_const_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == ADDR_W'(RO_OFF) |-> bus_rdata == RO_VALUE);

  // R2: address register holds only its two fields
  assert_addr_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q & ~ADDR_KEEP) == 32'h0);
endmodule

bind mgmt_frontend mgmt_frontend_chk #(
  .ADDR_W   (ADDR_W),
  .RO_OFF   (GEN_BASE + 3),
  .RO_VALUE (RO_VALUE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .link_up   (link_up),
  .cmd_q     (cmd_q),
  .addr_q    (addr_q),
  .rdat_q    (rdat_q),
  .phy_ctrl  (phy_ctrl),
  .phy_stat  (phy_stat)
);

// File: tb/tb_mgmt_frontend.sv
`timescale 1ns/1ps
module tb_mgmt_frontend;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        link_up;

  int checks   = 0;
  int failures = 0;
  logic mon_req = 1'b0;
  logic done    = 1'b0;

  typedef struct {
    logic [3:0]  a;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  mgmt_frontend dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .link_up   (link_up)
  );

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    it.a = a; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    mon_req = 1'b1;
    @(negedge clk);
    mon_req = 1'b0;
  endtask

  task automatic read_cycle();
    wr(4'd0, 32'h0);
    wr(4'd0, 32'h1);
  endtask

  // monitor: pops expected items and compares
  always @(posedge clk) begin
    item_t it;
    if (mon_req) begin
      #2;
      it = sb_q.pop_front();
      checks++;
      if (bus_rdata !== it.exp) begin
        failures++;
        $display("FAIL %s addr=%0d actual=%08h expected=%08h", it.tag, it.a, bus_rdata, it.exp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; link_up = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(4'd0, 32'h0, "R1 cmd reset");
    rd(4'd1, 32'h0, "R1 addr reset");
    rd(4'd2, 32'h0, "R1 wdata reset");
    rd(4'd3, 32'h0, "R1 rdata reset");
    wr(4'd0, 32'h1);
    rd(4'd3, 32'h0000_1140, "R1 R4 phy ctrl reset via read");
    rd(4'd0, 32'h1, "R3 cmd readback");

    // R3 no re-trigger while bit held
    wr(4'd1, 32'd10);
    wr(4'd0, 32'h1);
    rd(4'd3, 32'h0000_1140, "R3 held bit no new read");
    read_cycle();
    rd(4'd3, 32'h0000_1800, "R5 register 10 constant");

    // R2 field masking, R5 other register
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, 32'h0000_1F1F, "R2 address fields only");
    read_cycle();
    rd(4'd3, 32'h0, "R5 register 31 reads 0");

    // R4 / R9 status and link
    wr(4'd1, 32'd1);
    read_cycle();
    rd(4'd3, 32'h0000_7809, "R4 status link down");
    link_up = 1'b1;
    read_cycle();
    rd(4'd3, 32'h0000_780D, "R9 status link up");
    link_up = 1'b0;
    read_cycle();
    rd(4'd3, 32'h0000_7809, "R9 status link down again");

    // R6 / R7 control write
    wr(4'd1, 32'd0);
    wr(4'd2, 32'hABCD_FFFF);
    rd(4'd2, 32'h0000_FFFF, "R6 wdata low half");
    read_cycle();
    rd(4'd3, 32'h0000_7EFF, "R7 ctrl bits 15 and 8 cleared");
    wr(4'd1, 32'd2);
    wr(4'd2, 32'h0000_1234);
    read_cycle();
    rd(4'd3, 32'h0, "R5 register 2 reads 0");
    wr(4'd1, 32'd0);
    read_cycle();
    rd(4'd3, 32'h0000_7EFF, "R7 write to other register ignored");

    // R8 PHY address ignored
    wr(4'd1, 32'h0000_1F00);
    wr(4'd2, 32'h0000_9140);
    wr(4'd1, 32'h0000_0500);
    read_cycle();
    rd(4'd3, 32'h0000_1040, "R8 phy address ignored");

    // R13 read-data not bus writable
    wr(4'd3, 32'h0000_DEAD);
    rd(4'd3, 32'h0000_1040, "R13 rdata write ignored");

    // R10 / R11 / R12 general registers
    wr(4'd4, 32'h1234_5678);
    rd(4'd4, 32'h1234_5678, "R10 read-write");
    wr(4'd5, 32'h0000_AAAA);
    rd(4'd5, 32'h0, "R10 write-only reads 0");
    rd(4'd6, 32'h0000_00FF, "R11 w1c reset");
    wr(4'd6, 32'h0000_000F);
    rd(4'd6, 32'h0000_00F0, "R11 w1c clear");
    wr(4'd6, 32'h0);
    rd(4'd6, 32'h0000_00F0, "R11 w1c zero write");
    rd(4'd7, 32'h0001_0001, "R12 read-only value");
    wr(4'd7, 32'h0);
    rd(4'd7, 32'h0001_0001, "R12 read-only ignores write");
    wr(4'd9, 32'h55);
    rd(4'd9, 32'h0, "R12 unmapped reads 0");
    rd(4'd4, 32'h1234_5678, "R12 unmapped write touched nothing");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule